// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This engine performs maintenance on a physically indexed, physically tagged cache. Software asks for a clean, an invalidate or a clean-plus-invalidate of one line, and for a clean or an invalidate of an inclusive address range. It can also ask for a sweep that invalidates the whole cache. Each request is turned into a stream of single-line operations toward the tag and data arrays. Each line operation is held until the array acknowledges it.

A range request takes two register writes. The first write parks the lower bound in a holding register and does nothing else. The second write carries the upper bound, and its register select chooses the kind of range operation. Address translation is done once, on the lower bound only, so a range must stay inside one page. A request that crosses a page is rejected with an error pulse.

While a request is in progress, the stall output holds the requester back. Any register write that arrives during that time is dropped. When the write-through override input is high, the cache never holds dirty data, so clean work is skipped.

Top module: `cache_maint_engine`

## Requirements
- R1: A range operation visits every 32-byte line whose first byte address lies in the inclusive window [lower, upper]. It visits them in ascending order, 32 bytes apart. If no line start falls in the window, the operation issues no line operations and still gives its done pulse.
- R2: A write with select 0 only stores the lower bound. A later write with select 1 (range clean) or select 2 (range invalidate) starts the range operation using the most recently stored lower bound. A select-0 write on its own leaves stall and lineReq low.
- R3: stall is high from the cycle after an accepted command write through the cycle that carries done, and low otherwise. Every accepted command that is not rejected gives exactly one single-cycle done pulse.
- R4: A range command whose upper bound is in a different page (4096 bytes) from the stored lower bound issues no line operations. It raises rangeErr for one cycle, with stall and done low.
- R5: The single-line commands issue exactly one line operation at the written address rounded down to 32 bytes. Select 3 issues a clean, select 4 an invalidate and select 5 a clean-plus-invalidate. lineOp encodes clean as 1, invalidate as 2 and clean-plus-invalidate as 3.
- R6: Select 6 issues invalidate operations on indices 0 up to NUM_LINES-1 in order, with lineIsIndex high, and then gives done.
- R7: With wtOverride high, range clean and single-line clean issue no line operations and complete with done. Single-line clean-plus-invalidate issues an invalidate only. Invalidate commands are unaffected.
- R8: Only one line operation is outstanding at a time. lineReq, lineAddr, lineOp and lineIsIndex hold steady until lineAck. The next line is presented only after that acknowledge.
- R9: Register writes that arrive while stall is high are ignored, and this includes writes to the lower-bound register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wtOverride | input | 1 | Cache forced to write-through; clean work is skipped |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Register select / command code (0..6) |
| regWrData | input | ADDR_W | Address carried by the write |
| stall | output | 1 | Requester hold while a command runs |
| lineReq | output | 1 | Line operation request toward the arrays |
| lineOp | output | 2 | Line operation: 1 clean, 2 invalidate, 3 both |
| lineAddr | output | ADDR_W | Line address, or set/way index during a sweep |
| lineIsIndex | output | 1 | lineAddr carries an index instead of an address |
| lineAck | input | 1 | Array accepted the current line operation |
| done | output | 1 | One-cycle completion pulse |
| rangeErr | output | 1 | One-cycle pulse for a page-crossing range |

## Verification
The hardest case to reach is a register write that lands while a walk is still in progress. The bench reaches it by withholding lineAck after a range launch. With the engine held mid-walk, it writes a new lower bound and issues further commands. It then releases the acknowledges and shows that only the original lines appear. A follow-up range command then runs from the old lower bound, which proves that the held write left the stored bound unchanged. Acknowledges otherwise arrive on a pseudo-random pattern, so the hold-until-acknowledge behaviour is exercised across long runs, including a full 128-line page.

// File: rtl/cache_maint_pkg.sv
`timescale 1ns/1ps
package cache_maint_pkg;

  typedef enum logic [2:0] {
    SEL_LOWER  = 3'd0,
    SEL_RCLEAN = 3'd1,
    SEL_RINV   = 3'd2,
    SEL_LCLEAN = 3'd3,
    SEL_LINV   = 3'd4,
    SEL_LFLUSH = 3'd5,
    SEL_INVALL = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_INV   = 2'd2,
    OP_FLUSH = 2'd3
  } lineOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLower;
    logic loadRange;
    logic loadLine;
    logic loadSweep;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/cme_ctrl.sv
`timescale 1ns/1ps
module cme_ctrl
  import cache_maint_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wtOverride,
  input  logic      regWrEn,
  input  logic [2:0] regWrSel,
  input  logic      lineAck,
  input  logic      pageErr,
  input  logic      emptyRange,
  input  logic      isLast,
  output dpStrobe_t strb,
  output logic      lineReq,
  output logic [1:0] lineOp,
  output logic      stall,
  output logic      done,
  output logic      rangeErr
);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_FIN} state_e;

  state_e  state, nextState;
  lineOp_e opReg, nextOp;
  logic    errReg, nextErr;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextOp    = opReg;
    nextErr   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (regWrEn) begin
          case (regSel_e'(regWrSel))
            SEL_LOWER: strb.loadLower = 1'b1;
            SEL_RCLEAN: begin
              if (pageErr) nextErr = 1'b1;
              else if (wtOverride || emptyRange) nextState = S_FIN;
              else begin
                strb.loadRange = 1'b1;
                nextOp         = OP_CLEAN;
                nextState      = S_WALK;
              end
            end
            SEL_RINV: begin
              if (pageErr) nextErr = 1'b1;
              else if (emptyRange) nextState = S_FIN;
              else begin
                strb.loadRange = 1'b1;
                nextOp         = OP_INV;
                nextState      = S_WALK;
              end
            end
            SEL_LCLEAN: begin
              if (wtOverride) nextState = S_FIN;
              else begin
                strb.loadLine = 1'b1;
                nextOp        = OP_CLEAN;
                nextState     = S_WALK;
              end
            end
            SEL_LINV: begin
              strb.loadLine = 1'b1;
              nextOp        = OP_INV;
              nextState     = S_WALK;
            end
            SEL_LFLUSH: begin
              strb.loadLine = 1'b1;
              nextOp        = wtOverride ? OP_INV : OP_FLUSH;
              nextState     = S_WALK;
            end
            SEL_INVALL: begin
              strb.loadSweep = 1'b1;
              nextOp         = OP_INV;
              nextState      = S_WALK;
            end
            default: ;
          endcase
        end
      end
      S_WALK: begin
        if (lineAck) begin
          if (isLast) nextState = S_FIN;
          else strb.advance = 1'b1;
        end
      end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_NONE;
      errReg <= 1'b0;
    end else begin
      state  <= nextState;
      opReg  <= nextOp;
      errReg <= nextErr;
    end
  end

  assign lineReq  = (state == S_WALK);
  assign lineOp   = lineReq ? opReg : OP_NONE;
  assign stall    = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign rangeErr = errReg;

endmodule

// File: rtl/cme_datapath.sv
`timescale 1ns/1ps
module cme_datapath
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_LINES  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              idxMode,
  output logic              pageErr,
  output logic              emptyRange,
  output logic              isLast
);

  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));
  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(NUM_LINES - 1);

  logic [ADDR_W-1:0] lowerReg, lastAddr;
  logic [ADDR_W:0]   roundUp;
  logic [ADDR_W-1:0] firstLine, endLine, stepAmt;

  // first line start at or above the lower bound, with carry out of the top
  assign roundUp   = {1'b0, lowerReg} + {1'b0, ADDR_W'(LINE_BYTES - 1)};
  assign firstLine = roundUp[ADDR_W-1:0] & LINE_MASK;
  assign endLine   = wrData & LINE_MASK;

  assign pageErr    = (lowerReg >> PAGE_SH) != (wrData >> PAGE_SH);
  assign emptyRange = roundUp[ADDR_W] || (firstLine > endLine);
  assign isLast     = (curAddr == lastAddr);
  assign stepAmt    = idxMode ? ADDR_W'(1) : LINE_STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowerReg <= '0;
      curAddr  <= '0;
      lastAddr <= '0;
      idxMode  <= 1'b0;
    end else begin
      if (strb.loadLower) lowerReg <= wrData;
      if (strb.loadRange) begin
        curAddr  <= firstLine;
        lastAddr <= endLine;
        idxMode  <= 1'b0;
      end
      if (strb.loadLine) begin
        curAddr  <= endLine;
        lastAddr <= endLine;
        idxMode  <= 1'b0;
      end
      if (strb.loadSweep) begin
        curAddr  <= '0;
        lastAddr <= LAST_IDX;
        idxMode  <= 1'b1;
      end
      if (strb.advance) curAddr <= curAddr + stepAmt;
    end
  end

endmodule

// File: rtl/cache_maint_engine.sv
`timescale 1ns/1ps
module cache_maint_engine
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_LINES  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wtOverride,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              stall,
  output logic              lineReq,
  output logic [1:0]        lineOp,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              lineIsIndex,
  input  logic              lineAck,
  output logic              done,
  output logic              rangeErr
);

  dpStrobe_t strb;
  logic pageErr, emptyRange, isLast;

  cme_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wtOverride (wtOverride),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .lineAck    (lineAck),
    .pageErr    (pageErr),
    .emptyRange (emptyRange),
    .isLast     (isLast),
    .strb       (strb),
    .lineReq    (lineReq),
    .lineOp     (lineOp),
    .stall      (stall),
    .done       (done),
    .rangeErr   (rangeErr)
  );

  cme_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_LINES  (NUM_LINES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .curAddr    (lineAddr),
    .idxMode    (lineIsIndex),
    .pageErr    (pageErr),
    .emptyRange (emptyRange),
    .isLast     (isLast)
  );

endmodule

// File: rtl/cme_checker.sv
`timescale 1ns/1ps
module cme_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              lineReq,
  input logic [1:0]        lineOp,
  input logic [ADDR_W-1:0] lineAddr,
  input logic              lineIsIndex,
  input logic              lineAck,
  input logic              done,
  input logic              rangeErr
);

  localparam int LINE_SH = $clog2(LINE_BYTES);

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineReq && !lineAck |=> lineReq && $stable(lineAddr) && $stable(lineOp) && $stable(lineIsIndex));

  p_req_under_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> stall);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !stall);

  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> !stall && !lineReq && !done);

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    lineReq && lineAck && !lineIsIndex |=>
      !lineReq || (lineAddr == $past(lineAddr) + ADDR_W'(LINE_BYTES)));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineReq && lineAck && lineIsIndex |=> !lineReq || (lineAddr == $past(lineAddr) + ADDR_W'(1)));

  p_line_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineReq && !lineIsIndex |-> lineAddr[LINE_SH-1:0] == '0);

  p_op_defined_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> lineOp != 2'd0);

endmodule

bind cache_maint_engine cme_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .stall       (stall),
  .lineReq     (lineReq),
  .lineOp      (lineOp),
  .lineAddr    (lineAddr),
  .lineIsIndex (lineIsIndex),
  .lineAck     (lineAck),
  .done        (done),
  .rangeErr    (rangeErr)
);

// File: tb/sim_cache_maint_engine.sv
`timescale 1ns/1ps
module sim_cache_maint_engine;

  localparam int AW = 32;
  localparam int NL = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wtOverride = 1'b0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regWrSel = '0;
  logic [AW-1:0] regWrData = '0;
  logic          stall, lineReq, lineIsIndex, done, rangeErr;
  logic [1:0]    lineOp;
  logic [AW-1:0] lineAddr;
  logic          lineAck = 1'b0;

  cache_maint_engine #(.ADDR_W(AW), .LINE_BYTES(32), .PAGE_BYTES(4096), .NUM_LINES(NL)) u0 (
    .clk(clk), .rstN(rstN), .wtOverride(wtOverride), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .stall(stall), .lineReq(lineReq),
    .lineOp(lineOp), .lineAddr(lineAddr), .lineIsIndex(lineIsIndex),
    .lineAck(lineAck), .done(done), .rangeErr(rangeErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [AW+2:0] expQ[$];
  string         tagQ[$];
  logic          ackEn = 1'b1;
  logic [7:0]    lfsr = 8'h5A;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // monitor: decides the acknowledge and compares each accepted line op
  always @(negedge clk) begin
    lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    lineAck = ackEn && lineReq && (lfsr[0] || lfsr[2]);
    if (lineAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected line op", 64'({lineIsIndex, lineOp, lineAddr}), 64'd0);
      end else begin
        logic [AW+2:0] item;
        string tg;
        item = expQ.pop_front();
        tg   = tagQ.pop_front();
        check(item === {lineIsIndex, lineOp, lineAddr}, tg, "line op {idx,op,addr}",
              64'({lineIsIndex, lineOp, lineAddr}), 64'(item));
      end
    end
  end

  task automatic pushItem(input logic idx, input logic [1:0] op, input logic [AW-1:0] a,
                          input string req);
    expQ.push_back({idx, op, a});
    tagQ.push_back(req);
  endtask

  task automatic pushRange(input longint lo, input longint hi, input logic [1:0] op,
                           input string req);
    for (longint a = ((lo + 31) / 32) * 32; a <= (hi / 32) * 32; a += 32)
      pushItem(1'b0, op, AW'(a), req);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrSel  = sel;
    regWrData = data;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, "done pulse", 64'(done), 64'd1);
    check(expQ.size() == 0, req, "lines outstanding", 64'(expQ.size()), 64'd0);
    @(negedge clk);
    check(!stall && !done, "R3", "stall/done after completion", 64'({stall, done}), 64'd0);
  endtask

  task automatic cmd(input logic [2:0] sel, input logic [AW-1:0] data, input string req);
    wr(sel, data);
    check(stall == 1'b1, "R3", "stall after launch", 64'(stall), 64'd1);
    waitDone(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({stall, lineReq, done, rangeErr} == 4'b0, "R3", "reset outputs",
          64'({stall, lineReq, done, rangeErr}), 64'd0);

    // R2: lower-bound write alone does nothing
    wr(3'd0, 32'h1000);
    repeat (4) begin
      @(negedge clk);
      check(!stall && !lineReq, "R2", "idle after lower write", 64'({stall, lineReq}), 64'd0);
    end

    // R1: aligned range clean
    pushRange(32'h1000, 32'h1060, 2'd1, "R1");
    cmd(3'd1, 32'h1060, "R1");

    // R1: unaligned bounds, range invalidate
    wr(3'd0, 32'h2010);
    pushRange(32'h2010, 32'h207F, 2'd2, "R1");
    cmd(3'd2, 32'h207F, "R1");

    // R2: newer lower bound replaces the older one
    wr(3'd0, 32'h3400);
    wr(3'd0, 32'h3480);
    pushRange(32'h3480, 32'h34C0, 2'd2, "R2");
    cmd(3'd2, 32'h34C0, "R2");

    // R1: empty window
    wr(3'd0, 32'h5010);
    cmd(3'd2, 32'h501F, "R1");

    // R4: page crossing
    wr(3'd0, 32'h2FE0);
    wr(3'd2, 32'h3000);
    check(rangeErr && !stall, "R4", "error pulse, no stall", 64'({rangeErr, stall}), 64'h2);
    @(negedge clk);
    check(!rangeErr && !stall && !lineReq, "R4", "quiet after error",
          64'({rangeErr, stall, lineReq}), 64'd0);

    // R5: single-line commands
    pushItem(1'b0, 2'd1, 32'h4000, "R5");
    cmd(3'd3, 32'h4013, "R5");
    pushItem(1'b0, 2'd2, 32'h40A0, "R5");
    cmd(3'd4, 32'h40BF, "R5");
    pushItem(1'b0, 2'd3, 32'h4100, "R5");
    cmd(3'd5, 32'h4100, "R5");

    // R6: invalidate-all sweep
    for (int i = 0; i < NL; i++) pushItem(1'b1, 2'd2, AW'(i), "R6");
    cmd(3'd6, 32'h0, "R6");

    // R1: full page walk
    wr(3'd0, 32'h6000);
    pushRange(32'h6000, 32'h6FFF, 2'd1, "R1");
    cmd(3'd1, 32'h6FFF, "R1");

    // R7: write-through override
    wtOverride = 1'b1;
    wr(3'd0, 32'h7000);
    cmd(3'd1, 32'h70E0, "R7");
    cmd(3'd3, 32'h7020, "R7");
    pushItem(1'b0, 2'd2, 32'h7040, "R7");
    cmd(3'd5, 32'h7041, "R7");
    pushRange(32'h7000, 32'h7020, 2'd2, "R7");
    cmd(3'd2, 32'h7020, "R7");
    wtOverride = 1'b0;

    // R9: writes during a held walk are dropped
    ackEn = 1'b0;
    wr(3'd0, 32'h8000);
    pushRange(32'h8000, 32'h8040, 2'd2, "R9");
    wr(3'd2, 32'h8040);
    wr(3'd0, 32'h9000);
    wr(3'd4, 32'h9100);
    wr(3'd6, 32'h0);
    check(stall && lineReq, "R8", "request held without ack", 64'({stall, lineReq}), 64'h3);
    ackEn = 1'b1;
    waitDone("R9");
    repeat (3) begin
      @(negedge clk);
      check(!lineReq && !stall, "R9", "no work from dropped writes", 64'({lineReq, stall}), 64'd0);
    end
    pushRange(32'h8000, 32'h8020, 2'd1, "R9");
    cmd(3'd1, 32'h8020, "R9");

    summary();
    $finish;
  end

endmodule